// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Unit

This block is the interrupt side of one peripheral on an 8-bit bus where the CPU strobes are machine-cycle (/M1), I/O request (/IORQ) and read (/RD). The unit runs on the CPU clock and watches every bus cycle, not only the cycles that address it. A local request pulse makes the unit pending. When its chain enable input is high it pulls its interrupt line low. On the acknowledge cycle it places its programmed vector on the data bus.

Priority is set by position in a chain. Each unit's enable output feeds the enable input of the next, lower-priority unit. A unit holds its enable output low while it is pending or being serviced, and also whenever its own enable input is low. Service ends when the unit decodes the two-byte return-from-interrupt opcode in consecutive instruction fetches. There is no end-of-interrupt register write. Because a handler may still be running when a higher unit raises a new request, a pending unit briefly lets the chain enable through while the first opcode byte is armed. This lets the serviced unit further down recognise its return.

States: IDLE (nothing to do), PEND (request held, may raise the interrupt), ACK (vector being driven), SERV (under service). Transitions:
- IDLE→PEND on an enabled request pulse.
- PEND→ACK on an acknowledge cycle with the chain enable in high.
- ACK→SERV when the acknowledge strobes drop.
- SERV→IDLE or SERV→PEND on a decoded return while the chain enable in is high. It goes to PEND if a request arrived during service.

The opcode decoder has two states, WAIT and ARMED. WAIT→ARMED on a fetched 0xED. ARMED→WAIT on the next fetched byte, whatever it is. When that byte is 0x4D, this step also produces the return pulse.

Top module: `irq_chain_unit`

## Requirements
- R1: After reset the interrupt output is high, the vector output enable is low, and the chain enable out follows chain enable in.
- R2: An enabled request pulse makes the unit pending. From the next cycle, the interrupt output is low if chain enable in is high, and chain enable out is low.
- R3: A request that arrives while chain enable in is low raises no interrupt. It stays pending, and the interrupt output goes low once chain enable in returns high.
- R4: An acknowledge cycle is /M1 low together with /IORQ low. If the unit is pending with chain enable in high, it drives the vector output enable high and presents its programmed vector in that same cycle. Units further down the chain stay off the bus.
- R5: When the acknowledge strobes drop, the unit enters service. Its interrupt output is high and its chain enable out stays low.
- R6: An instruction fetch is /M1 and /RD low with /IORQ high, and its byte is sampled on the first clock of the strobe. A fetch of 0xED followed by a fetch of 0x4D ends service when chain enable in is high. Chain enable out then returns high, unless a higher unit blocks it or the unit has a request of its own.
- R7: After a fetched 0xED, a fetch of any byte other than 0x4D returns the decoder to waiting. A later lone 0x4D does not end service.
- R8: A return sequence seen while chain enable in is low leaves the unit in service.
- R9: While its decoder is armed by 0xED, a pending unit that is not in service passes chain enable in through to chain enable out.
- R10: With the enable bit clear, a request pulse is ignored. The interrupt output stays high and chain enable out stays high.
- R11: A request pulse during acknowledge or service is held. When service ends the unit goes straight back to pending.
- R12: Chain enable out is low whenever chain enable in is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| chain_en_in | input | 1 | Priority enable from the higher unit (high = allowed) |
| chain_en_out | output | 1 | Priority enable to the lower unit |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_in | input | DW | Data bus as seen by the unit |
| req_pulse | input | 1 | One-cycle local interrupt request |
| cfg_we | input | 1 | Load the vector and enable bit |
| cfg_vector | input | DW | Vector value to load |
| cfg_enable | input | 1 | Interrupt enable bit to load |
| int_n | output | 1 | Interrupt request, active low (open-drain style) |
| vec_out | output | DW | Vector for the data bus, zero when not driven |
| vec_oe | output | 1 | Data bus output enable for the vector |

## Verification
Two functions can fall in the same cycle. One is the 0x4D fetch that ends one unit's service. The other is the arming release of a higher unit that has just become pending. The lower unit's return is only recognised because the higher unit lets the enable through in that very cycle. A held request can also land in that cycle and send the cleared unit straight back to pending. The bench builds a three-unit chain and provokes this case directly: a higher unit raises a request while the middle unit is in service and already holds a request of its own. It then judges the outcome by the enable wire between the units during the armed cycle, and by which vector each following acknowledge returns. A seeded random phase repeats the mix against a chain model.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_ACK,
        ST_SERV
    } irq_state_t;

    typedef enum logic {
        DEC_WAIT,
        DEC_ARMED
    } dec_state_t;

endpackage

// File: rtl/reti_decoder.sv
module reti_decoder
    import irq_chain_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] PREFIX_OP = 8'hED,
    parameter logic [DW-1:0] FINAL_OP  = 8'h4D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m1_n,
    input  logic          rd_n,
    input  logic          iorq_n,
    input  logic [DW-1:0] bus_in,
    output logic          armed,
    output logic          reti_hit
);

    dec_state_t state, state_nxt;
    logic fetch, fetch_q, fetch_start;

    assign fetch       = !m1_n && !rd_n && iorq_n;
    assign fetch_start = fetch && !fetch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= DEC_WAIT;
            fetch_q <= 1'b0;
        end else begin
            state   <= state_nxt;
            fetch_q <= fetch;
        end
    end

    always_comb begin
        state_nxt = state;
        reti_hit  = 1'b0;
        if (fetch_start) begin
            unique case (state)
                DEC_WAIT: begin
                    if (bus_in == PREFIX_OP) state_nxt = DEC_ARMED;
                end
                DEC_ARMED: begin
                    state_nxt = DEC_WAIT;
                    reti_hit  = (bus_in == FINAL_OP);
                end
                default: state_nxt = DEC_WAIT;
            endcase
        end
    end

    assign armed = (state == DEC_ARMED);

    assert_prefix_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_start && bus_in == PREFIX_OP && state == DEC_WAIT) |=> armed);

    assert_return_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reti_hit |=> !armed);

endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic irq_en,
    input  logic en_in,
    input  logic ack_on,
    input  logic reti_hit,
    input  logic armed,
    output logic int_n,
    output logic en_out,
    output logic vec_oe
);

    irq_state_t state, state_nxt;
    logic held_q;
    logic take_req;
    logic leave_serv;

    assign take_req   = req && irq_en;
    assign leave_serv = (state == ST_SERV) && reti_hit && en_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            held_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (leave_serv)
                held_q <= 1'b0;
            else if (take_req && (state == ST_ACK || state == ST_SERV))
                held_q <= 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (take_req)        state_nxt = ST_PEND;
            ST_PEND: if (ack_on && en_in) state_nxt = ST_ACK;
            ST_ACK:  if (!ack_on)         state_nxt = ST_SERV;
            ST_SERV: if (leave_serv)
                         state_nxt = (held_q || take_req) ? ST_PEND : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        int_n  = 1'b1;
        vec_oe = 1'b0;
        en_out = 1'b0;
        unique case (state)
            ST_IDLE: en_out = en_in;
            ST_PEND: begin
                int_n  = !en_in;
                vec_oe = ack_on && en_in;
                en_out = en_in && armed;
            end
            ST_ACK:  vec_oe = ack_on;
            ST_SERV: en_out = 1'b0;
            default: en_out = 1'b0;
        endcase
    end

    assert_request_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && take_req) |=> (state == ST_PEND));

    assert_ack_to_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && !ack_on) |=> (state == ST_SERV));

    assert_return_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERV && reti_hit && en_in) |=> (state != ST_SERV));

    assert_blocked_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERV && !en_in) |=> (state == ST_SERV));

    assert_disabled_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !irq_en) |=> (state == ST_IDLE));

    assert_held_returns_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_serv && held_q) |=> (state == ST_PEND));

endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import irq_chain_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] PREFIX_OP = 8'hED,
    parameter logic [DW-1:0] FINAL_OP  = 8'h4D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_en_in,
    output logic          chain_en_out,
    input  logic          m1_n,
    input  logic          iorq_n,
    input  logic          rd_n,
    input  logic [DW-1:0] bus_in,
    input  logic          req_pulse,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_vector,
    input  logic          cfg_enable,
    output logic          int_n,
    output logic [DW-1:0] vec_out,
    output logic          vec_oe
);

    logic [DW-1:0] vector_q;
    logic          enable_q;
    logic          ack_on;
    logic          armed;
    logic          reti_hit;

    assign ack_on = !m1_n && !iorq_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vector_q <= '0;
            enable_q <= 1'b0;
        end else if (cfg_we) begin
            vector_q <= cfg_vector;
            enable_q <= cfg_enable;
        end
    end

    reti_decoder #(
        .DW(DW), .PREFIX_OP(PREFIX_OP), .FINAL_OP(FINAL_OP)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .rd_n(rd_n), .iorq_n(iorq_n),
        .bus_in(bus_in), .armed(armed), .reti_hit(reti_hit)
    );

    irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req_pulse), .irq_en(enable_q),
        .en_in(chain_en_in), .ack_on(ack_on), .reti_hit(reti_hit),
        .armed(armed), .int_n(int_n), .en_out(chain_en_out), .vec_oe(vec_oe)
    );

    assign vec_out = vec_oe ? vector_q : '0;

    assert_vector_only_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (!m1_n && !iorq_n));

    assert_chain_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_in |-> !chain_en_out);

endmodule

// File: tb/irq_chain_unit_test.sv
`timescale 1ns/1ps
module irq_chain_unit_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       top_en = 1'b1;
    logic       m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1;
    logic [7:0] bus = 8'h00;
    logic       req [3];
    logic       cwe [3];
    logic [7:0] cvec [3];
    logic       cen [3];
    logic       intn [3];
    logic [7:0] vo [3];
    logic       oe [3];
    logic       chain [4];

    int checks = 0;
    int fails = 0;
    bit pend [3];
    bit serv [3];
    bit enab [3];
    logic [7:0] vecs [3];

    assign chain[0] = top_en;

    irq_chain_unit dev_hi (
        .clk(clk), .rst_n(rst_n), .chain_en_in(chain[0]), .chain_en_out(chain[1]),
        .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n), .bus_in(bus), .req_pulse(req[0]),
        .cfg_we(cwe[0]), .cfg_vector(cvec[0]), .cfg_enable(cen[0]),
        .int_n(intn[0]), .vec_out(vo[0]), .vec_oe(oe[0]));

    irq_chain_unit uut (
        .clk(clk), .rst_n(rst_n), .chain_en_in(chain[1]), .chain_en_out(chain[2]),
        .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n), .bus_in(bus), .req_pulse(req[1]),
        .cfg_we(cwe[1]), .cfg_vector(cvec[1]), .cfg_enable(cen[1]),
        .int_n(intn[1]), .vec_out(vo[1]), .vec_oe(oe[1]));

    irq_chain_unit dev_lo (
        .clk(clk), .rst_n(rst_n), .chain_en_in(chain[2]), .chain_en_out(chain[3]),
        .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n), .bus_in(bus), .req_pulse(req[2]),
        .cfg_we(cwe[2]), .cfg_vector(cvec[2]), .cfg_enable(cen[2]),
        .int_n(intn[2]), .vec_out(vo[2]), .vec_oe(oe[2]));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eligible();
        for (int i = 0; i < 3; i++) begin
            if (serv[i]) return -1;
            if (pend[i]) return i;
        end
        return -1;
    endfunction

    function automatic bit any_busy();
        for (int i = 0; i < 3; i++) if (pend[i] || serv[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int int_any();
        return (intn[0] && intn[1] && intn[2]) ? 1 : 0;
    endfunction

    task automatic configure(input int i, input logic [7:0] v, input bit e);
        @(negedge clk);
        cwe[i] = 1'b1; cvec[i] = v; cen[i] = e;
        @(negedge clk);
        cwe[i] = 1'b0;
        vecs[i] = v; enab[i] = e;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        req[i] = 1'b1;
        @(negedge clk);
        req[i] = 1'b0;
        if (enab[i]) pend[i] = 1'b1;
        #1;
    endtask

    task automatic fetch(input logic [7:0] b);
        @(negedge clk);
        m1_n = 1'b0; rd_n = 1'b0; bus = b;
        @(negedge clk);
        m1_n = 1'b1; rd_n = 1'b1; bus = 8'h00;
        #1;
    endtask

    // model check: valid when top_en is high and no decoder is armed
    task automatic check_model(input string tag);
        int e;
        e = eligible();
        check(int_any() == ((e >= 0) ? 0 : 1), {tag, " int line"}, int_any(), (e >= 0) ? 0 : 1);
        check(chain[3] == !any_busy(), {tag, " chain end"}, chain[3], !any_busy());
    endtask

    task automatic do_ack(input string tag);
        int e;
        e = eligible();
        @(negedge clk);
        m1_n = 1'b0; iorq_n = 1'b0;
        #1;
        for (int i = 0; i < 3; i++) begin
            check(oe[i] == (i == e), {tag, " vector enable"}, oe[i], (i == e));
            if (i == e) check(vo[i] == vecs[i], {tag, " vector value"}, vo[i], vecs[i]);
        end
        @(negedge clk);
        m1_n = 1'b1; iorq_n = 1'b1;
        @(negedge clk);
        if (e >= 0) begin pend[e] = 1'b0; serv[e] = 1'b1; end
        #1;
    endtask

    task automatic do_reti();
        fetch(8'hED);
        fetch(8'h4D);
        for (int i = 0; i < 3; i++) begin
            if (serv[i]) begin serv[i] = 1'b0; break; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1977));
        for (int i = 0; i < 3; i++) begin
            req[i] = 0; cwe[i] = 0; cvec[i] = 0; cen[i] = 0;
            pend[i] = 0; serv[i] = 0; enab[i] = 0; vecs[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(int_any() == 1, "R1 int idle", int_any(), 1);
        check(!oe[0] && !oe[1] && !oe[2], "R1 no vector", oe[1], 0);
        check(chain[3] == 1'b1, "R1 chain passes", chain[3], 1);

        configure(0, 8'h10, 1);
        configure(1, 8'h20, 0);
        configure(2, 8'h30, 1);

        // R10 disabled unit ignores requests
        pulse(1);
        check(intn[1] == 1'b1, "R10 int stays high", intn[1], 1);
        check(chain[2] == 1'b1, "R10 chain stays high", chain[2], 1);
        configure(1, 8'h20, 1);

        // R2 request
        pulse(1);
        check(intn[1] == 1'b0, "R2 int low", intn[1], 0);
        check(chain[2] == 1'b0, "R2 chain out low", chain[2], 0);

        // R4 acknowledge, R5 service
        do_ack("R4");
        check(intn[1] == 1'b1, "R5 int released", intn[1], 1);
        check(chain[2] == 1'b0, "R5 chain held", chain[2], 0);

        // R7 broken sequence
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        check(chain[2] == 1'b0, "R7 still in service", chain[2], 0);

        // R11 held request, R9 arming release with higher pending
        pulse(1);
        pulse(0);
        check(intn[0] == 1'b0, "R2 higher int low", intn[0], 0);
        fetch(8'hED);
        check(chain[1] == 1'b1, "R9 pending unit releases chain", chain[1], 1);
        fetch(8'h4D);
        serv[1] = 1'b0;
        check_model("R6 cleared under pending higher");
        do_ack("R4 higher");
        do_reti();
        check(intn[1] == 1'b0, "R11 held request pending", intn[1], 0);
        do_ack("R11");
        do_reti();
        check_model("R6 all clear");

        // R3 request while blocked, R12
        top_en = 1'b0;
        pulse(2);
        check(int_any() == 1, "R3 no int while blocked", int_any(), 1);
        check(chain[3] == 1'b0, "R12 chain low", chain[3], 0);
        top_en = 1'b1;
        #1;
        check(intn[2] == 1'b0, "R3 int after unblock", intn[2], 0);
        do_ack("R4 lowest");
        do_reti();
        check_model("R6 lowest clear");

        // R8 return while blocked
        pulse(1);
        do_ack("R4 middle");
        top_en = 1'b0;
        fetch(8'hED); fetch(8'h4D);
        top_en = 1'b1;
        #1;
        check(chain[2] == 1'b0, "R8 service kept", chain[2], 0);
        do_reti();
        check(chain[3] == 1'b1, "R6 chain restored", chain[3], 1);

        // seeded random phase
        for (int n = 0; n < 300; n++) begin
            int r;
            r = $urandom % 4;
            if (r < 3) pulse(r);
            check_model("R2 random");
            if (eligible() >= 0 && ($urandom % 2) == 0) begin
                do_ack("R4 random");
            end else if (serv[0] || serv[1] || serv[2]) begin
                do_reti();
            end else begin
                @(negedge clk); #1;
            end
            check_model("R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule